// File: doc/BRIEF.md
# Power-On Load and Persistent-Write Sequencer

This block sequences start-up and persistent-register programming for a dual-channel converter control core. After reset, it keeps every converter output muted. It then issues one-cycle copy strobes to the register bank, in a fixed order: first the persistent data register of each channel, then the persistent mute/power-down control register, each copied into its working counterpart. It then waits out a fixed initialization interval before it lets the outputs follow the loaded codes and modes. The copied values themselves live in the register bank. Before any programming, that bank holds all-zero persistent data and a zero control byte.

The second function times persistent writes. The serial front end raises a request when it commits a write to persistent storage. The sequencer answers every request one cycle later with either an accept pulse or a reject pulse. Once a write is pending, the bus STOP pulse starts a busy window of a programmable number of clock cycles. While this window runs, the front end refuses its address and any further persistent write is rejected. A one-cycle done pulse marks the end of the window. Both interval lengths are parameters counted in clock cycles. The defaults correspond to 500 µs and 15 ms at 125 MHz.

Top module: `nv_boot_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `init_mute_o` is 1, `busy_o` is 0, `copy_stb_o` is all zeros, and the accept, reject and done pulses are 0.
- R2: Counting from reset release, rising edges 1, 2 and 3 make `copy_stb_o` equal to 001, 010 and 100 respectively, one edge apart. Bit i (i below NUM_DAC) copies channel i's persistent data register. Bit NUM_DAC copies the persistent control register. At most one bit is ever set.
- R3: `init_mute_o` stays 1 through the copy steps and for exactly INIT_CYCLES further cycles, falling after edge 4+INIT_CYCLES. Once low, it stays low until the next reset.
- R4: A reset applied during the initialization interval drives `init_mute_o` high again and restarts the whole sequence from the first copy strobe.
- R5: A STOP pulse seen while a persistent write is pending and the block is not busy raises `busy_o` after that edge. `busy_o` then stays 1 for exactly BUSY_CYCLES cycles.
- R6: A STOP pulse with no pending or same-cycle write request leaves `busy_o` at 0.
- R7: A request seen while `busy_o` is 1 gives a reject pulse and no accept pulse one cycle later. It does not lengthen or restart the busy window, and a later STOP does not start a new one. This also holds in the last busy cycle.
- R8: A request seen while `busy_o` is 0 gives an accept pulse one cycle later. If it arrives in the same cycle as STOP, busy starts at that STOP.
- R9: `wr_done_o` is 1 for exactly the one cycle in which `busy_o` has just fallen.
- R10: `copy_stb_o` stays all zeros once the outputs are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| stop_i | input | 1 | One-cycle pulse: bus STOP condition seen |
| wr_req_i | input | 1 | One-cycle pulse: persistent write committed by the front end |
| copy_stb_o | output | NUM_DAC+1 | Copy strobes persistent→working (data channels, then control) |
| init_mute_o | output | 1 | Holds all converter outputs muted during start-up |
| busy_o | output | 1 | Persistent write in progress; front end refuses its address |
| wr_accept_o | output | 1 | Request accepted (one cycle after request) |
| wr_reject_o | output | 1 | Request rejected because busy (one cycle after request) |
| wr_done_o | output | 1 | Busy window ended |

## Verification
Two collisions can fall on the same edge and are provoked on purpose. In the first, a write request and the STOP pulse are driven in the same cycle. The bench expects an accept pulse together with the start of a full-length busy window. In the second, a new request is placed on the final cycle of a busy window, exactly when the window closes. The bench expects a reject, busy falling on schedule with the done pulse, and no new window from a later STOP.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;

  typedef enum logic [1:0] {
    BOOT_HOLD,
    BOOT_COPY,
    BOOT_WAIT,
    BOOT_LIVE
  } boot_state_e;

  // Bits needed to count 0 .. limit-1
  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction

endpackage

// File: rtl/nvseq_boot.sv
module nvseq_boot
  import nvseq_pkg::*;
#(
  parameter int unsigned NUM_DAC     = 2,
  parameter int unsigned INIT_CYCLES = 62500
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [NUM_DAC:0]   copy_stb_o,
  output logic               mute_o
);
  localparam int unsigned NSTB = NUM_DAC + 1;
  localparam int unsigned IW   = cnt_width(NSTB);
  localparam int unsigned CW   = cnt_width(INIT_CYCLES);

  boot_state_e   state_q;
  logic [IW-1:0] idx_q;
  logic [CW-1:0] wait_q;
  logic          last_copy;
  logic          last_wait;

  assign last_copy = (idx_q == IW'(NSTB - 1));
  assign last_wait = (wait_q == CW'(INIT_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BOOT_HOLD;
      idx_q   <= '0;
      wait_q  <= '0;
    end else begin
      unique case (state_q)
        BOOT_HOLD: begin
          state_q <= BOOT_COPY;
          idx_q   <= '0;
        end
        BOOT_COPY: begin
          if (last_copy) begin
            state_q <= BOOT_WAIT;
            wait_q  <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        BOOT_WAIT: begin
          if (last_wait) state_q <= BOOT_LIVE;
          else           wait_q  <= wait_q + 1'b1;
        end
        default: state_q <= BOOT_LIVE;
      endcase
    end
  end

  assign copy_stb_o = (state_q == BOOT_COPY) ? (NSTB'(1) << idx_q) : '0;
  assign mute_o     = (state_q != BOOT_LIVE);

endmodule

// File: rtl/nvseq_wtimer.sv
module nvseq_wtimer
  import nvseq_pkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 1875000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_req_i,
  input  logic stop_i,
  output logic busy_o,
  output logic accept_o,
  output logic reject_o,
  output logic done_o,
  output logic pend_o
);
  localparam int unsigned CW = cnt_width(BUSY_CYCLES);

  logic          busy_q, pend_q, acc_q, rej_q, done_q;
  logic [CW-1:0] cnt_q;
  logic          take, start, window_end;

  assign take       = wr_req_i & ~busy_q;
  assign start      = stop_i & ~busy_q & (pend_q | take);
  assign window_end = busy_q & (cnt_q == CW'(BUSY_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      acc_q  <= 1'b0;
      rej_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      acc_q  <= take;
      rej_q  <= wr_req_i & busy_q;
      done_q <= window_end;
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        pend_q <= 1'b0;
      end else if (busy_q) begin
        if (window_end) busy_q <= 1'b0;
        else            cnt_q  <= cnt_q + 1'b1;
      end else if (take) begin
        pend_q <= 1'b1;
      end
    end
  end

  assign busy_o   = busy_q;
  assign accept_o = acc_q;
  assign reject_o = rej_q;
  assign done_o   = done_q;
  assign pend_o   = pend_q;

endmodule

// File: rtl/nv_boot_seq.sv
module nv_boot_seq #(
  parameter int unsigned NUM_DAC     = 2,
  parameter int unsigned INIT_CYCLES = 62500,
  parameter int unsigned BUSY_CYCLES = 1875000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_i,
  input  logic             wr_req_i,
  output logic [NUM_DAC:0] copy_stb_o,
  output logic             init_mute_o,
  output logic             busy_o,
  output logic             wr_accept_o,
  output logic             wr_reject_o,
  output logic             wr_done_o
);
  logic pend_w;

  nvseq_boot #(
    .NUM_DAC     (NUM_DAC),
    .INIT_CYCLES (INIT_CYCLES)
  ) u_boot (
    .clk        (clk),
    .rst_n      (rst_n),
    .copy_stb_o (copy_stb_o),
    .mute_o     (init_mute_o)
  );

  nvseq_wtimer #(
    .BUSY_CYCLES (BUSY_CYCLES)
  ) u_wtimer (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_req_i (wr_req_i),
    .stop_i   (stop_i),
    .busy_o   (busy_o),
    .accept_o (wr_accept_o),
    .reject_o (wr_reject_o),
    .done_o   (wr_done_o),
    .pend_o   (pend_w)
  );

endmodule

// File: rtl/nv_boot_seq_chk.sv
module nv_boot_seq_chk
  import nvseq_pkg::*;
#(
  parameter int unsigned NUM_DAC     = 2,
  parameter int unsigned BUSY_CYCLES = 1875000
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NUM_DAC:0] copy,
  input logic             mute,
  input logic             busy,
  input logic             accept,
  input logic             reject,
  input logic             done,
  input logic             wr_req,
  input logic             stop,
  input logic             pend
);
  localparam int unsigned RW = cnt_width(BUSY_CYCLES + 1) + 1;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  assert_copy_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(copy));
  assert_no_copy_live_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mute |-> (copy == '0));
  assert_mute_stays_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mute |=> !mute);
  assert_busy_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !busy && (pend || wr_req)) |=> busy);
  assert_busy_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_q < RW'(BUSY_CYCLES)));
  assert_stop_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !busy && !pend && !wr_req) |=> !busy);
  assert_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && busy) |=> (reject && !accept));
  assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !busy) |=> (accept && !reject));
  assert_done_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_done_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_q == RW'(BUSY_CYCLES)));

endmodule

bind nv_boot_seq nv_boot_seq_chk #(
  .NUM_DAC     (NUM_DAC),
  .BUSY_CYCLES (BUSY_CYCLES)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .copy   (copy_stb_o),
  .mute   (init_mute_o),
  .busy   (busy_o),
  .accept (wr_accept_o),
  .reject (wr_reject_o),
  .done   (wr_done_o),
  .wr_req (wr_req_i),
  .stop   (stop_i),
  .pend   (pend_w)
);

// File: tb/nv_boot_seq_bench.sv
`timescale 1ns/1ps
module nv_boot_seq_bench;
  localparam int unsigned NDAC = 2;
  localparam int unsigned INIT = 20;
  localparam int unsigned BUSY = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_i = 1'b0;
  logic wr_req_i = 1'b0;
  logic [NDAC:0] copy_stb_o;
  logic init_mute_o, busy_o, wr_accept_o, wr_reject_o, wr_done_o;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  always #4 clk = ~clk;

  nv_boot_seq #(.NUM_DAC(NDAC), .INIT_CYCLES(INIT), .BUSY_CYCLES(BUSY)) u_nv_boot_seq (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .wr_req_i(wr_req_i),
    .copy_stb_o(copy_stb_o), .init_mute_o(init_mute_o), .busy_o(busy_o),
    .wr_accept_o(wr_accept_o), .wr_reject_o(wr_reject_o), .wr_done_o(wr_done_o));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // advance one edge; sample point is 2 ns after the edge
  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    step(); step();
    chk("R1 mute in reset", int'(init_mute_o), 1);
    chk("R1 busy in reset", int'(busy_o), 0);
    chk("R1 copy in reset", int'(copy_stb_o), 0);
    chk("R1 pulses in reset", int'({wr_accept_o, wr_reject_o, wr_done_o}), 0);
    rst_n = 1'b1;
  endtask

  // boot from release; stops in WAIT after edge 4+k if k<INIT, else runs to live
  task automatic t_boot(input int wait_edges);
    chk("R1 copy before first edge", int'(copy_stb_o), 0);
    step(); chk("R2 strobe data0", int'(copy_stb_o), 1);
    chk("R3 mute during copy", int'(init_mute_o), 1);
    step(); chk("R2 strobe data1", int'(copy_stb_o), 2);
    step(); chk("R2 strobe ctrl", int'(copy_stb_o), 4);
    step(); chk("R2 strobes end", int'(copy_stb_o), 0);
    for (int i = 0; i < wait_edges && i < int'(INIT) - 1; i++) step();
    chk("R3 mute during wait", int'(init_mute_o), 1);
    if (wait_edges >= int'(INIT)) begin
      step();
      chk("R3 mute released", int'(init_mute_o), 0);
      chk("R10 no strobe live", int'(copy_stb_o), 0);
    end
  endtask

  task automatic t_restart();
    rst_n = 1'b0;
    step();
    chk("R4 mute on reset in wait", int'(init_mute_o), 1);
    rst_n = 1'b1;
    t_boot(INIT);
  endtask

  task automatic t_write_basic();
    wr_req_i = 1'b1; step(); wr_req_i = 1'b0;
    chk("R8 accept", int'(wr_accept_o), 1);
    chk("R8 no reject", int'(wr_reject_o), 0);
    chk("R5 idle before stop", int'(busy_o), 0);
    step(); step();
    stop_i = 1'b1; step(); stop_i = 1'b0;
    chk("R5 busy after stop", int'(busy_o), 1);
    for (int i = 1; i < int'(BUSY); i++) begin
      step();
      chk("R5 busy held", int'(busy_o), 1);
    end
    step();
    chk("R5 busy ends", int'(busy_o), 0);
    chk("R9 done pulse", int'(wr_done_o), 1);
    chk("R10 no strobe live", int'(copy_stb_o), 0);
    step();
    chk("R9 done single", int'(wr_done_o), 0);
  endtask

  task automatic t_stop_idle();
    stop_i = 1'b1; step(); stop_i = 1'b0;
    chk("R6 stop without write", int'(busy_o), 0);
    step();
    chk("R6 still idle", int'(busy_o), 0);
  endtask

  // request and STOP in the same cycle, then request in last busy cycle
  task automatic t_collisions();
    wr_req_i = 1'b1; stop_i = 1'b1; step(); wr_req_i = 1'b0; stop_i = 1'b0;
    chk("R8 same-cycle accept", int'(wr_accept_o), 1);
    chk("R8 same-cycle busy", int'(busy_o), 1);
    step(); step();
    wr_req_i = 1'b1; step(); wr_req_i = 1'b0;
    chk("R7 reject mid busy", int'(wr_reject_o), 1);
    chk("R7 no accept mid busy", int'(wr_accept_o), 0);
    // busy started 3 edges ago; move to last busy sample
    for (int i = 3; i < int'(BUSY) - 1; i++) step();
    chk("R7 still busy at last cycle", int'(busy_o), 1);
    wr_req_i = 1'b1; step(); wr_req_i = 1'b0;
    chk("R7 reject at last cycle", int'(wr_reject_o), 1);
    chk("R7 window not extended", int'(busy_o), 0);
    chk("R9 done at end", int'(wr_done_o), 1);
    stop_i = 1'b1; step(); stop_i = 1'b0;
    chk("R7 rejected write not pending", int'(busy_o), 0);
  endtask

  initial begin
    #3;
    t_reset_state();
    t_boot(5);
    t_restart();
    t_write_basic();
    t_stop_idle();
    t_collisions();
    step();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule